// File: doc/BRIEF.md
# Fixed-Point System Time Counter

This block keeps the local system time as a 64-bit fixed-point quantity. On every cycle of the local oscillator (marked by `osc_tick`) the count grows by a programmable increment. The increment is chosen so that software can turn the count into nanoseconds with a single right shift. The block also reports the shift that matches the loaded increment on `frac_shift`. Another choice of increment trims the frequency while the counter keeps running. Other timing blocks read the running value from `time_now`.

A small word-wide register port gives software three registers. Address 0 holds the increment, address 1 holds the low half of the time and address 2 holds the high half. The time is written by staging the low half and then writing the high half, which loads the whole value in one cycle. A read of the low half captures the high half at the same instant, so a low-then-high read pair always returns one coherent 64-bit sample.

The oscillator period depends on the link rate: 6.4 ns at 10 Gb/s and with no link, 64 ns at 1 Gb/s and 640 ns at 100 Mb/s. A preset strobe loads the matching default increment and shift for the current rate. The `NARROW` parameter picks a 24-bit increment field with an 8-bit period field in place of the 31-bit field. In that variant the defaults are reduced by seven bit positions.

Top module: `systime_accum`

## Requirements
- R1: On each clock edge where `osc_tick` is high, and no high-half write occurs, `time_now` grows by the current increment, modulo 2^64. Without a tick it holds its value.
- R2: After reset `time_now` is 0, the increment is 0x66666666 and `frac_shift` is 28. A `speed_apply` pulse loads the defaults for `link_speed`: 0 (10 Gb/s) or 3 (no link) gives 0x66666666 with shift 28, 1 (1 Gb/s) gives 0x40000000 with shift 24, and 2 (100 Mb/s) gives 0x50000000 with shift 21.
- R3: A write to address 0 replaces the increment without touching `time_now`. A tick in the same cycle as the write still adds the old increment, and the following ticks add the new one. In the wide variant the field is `reg_wdata[30:0]`, and a read of address 0 returns bit 31 as 0.
- R4: A write to address 1 only stages the low half. `time_now` does not change.
- R5: A write to address 2 loads `{reg_wdata, staged low half}` into the time in one cycle. The load overrides any tick in that cycle.
- R6: A read strobe returns its data on `reg_rdata` with `reg_rvalid` high one cycle later. A read of address 1 returns the live low half and captures the live high half. A read of address 2 returns that captured high half. A read of address 3 returns 0.
- R7: The time wraps from the top of the 64-bit range through zero without stalling.
- R8: When `NARROW` is 1, the increment field is bits 23:0 and a period field sits in bits 31:24. A preset loads the wide default shifted right by 7, with the shift reduced by 7 and the period set to 1. For example, 10 Gb/s reads back 0x01CCCCCC with shift 21, and 1 Gb/s reads back 0x01800000 with shift 17.
- R9: If `speed_apply` and a write to address 0 fall in the same cycle, the preset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One pulse per oscillator cycle |
| link_speed | input | 2 | Rate code: 0 10 Gb/s, 1 1 Gb/s, 2 100 Mb/s, 3 no link |
| speed_apply | input | 1 | Load default increment and shift for `link_speed` |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| time_now | output | 64 | Live fixed-point time |
| frac_shift | output | 6 | Right shift that turns the time into nanoseconds |

## Verification
The bench first loads a time just below a 32-bit carry. It reads the low half, lets one tick carry into the high half, and then reads the high half. A design without the capture register would return the incremented high word, not the captured one. An increment write is placed in the same cycle as a tick, and a high-half write is also placed in the same cycle as a tick. A design that applied the new increment too early, or let the tick add on top of the load, would be off by exactly one increment. A wrap from all ones also checks that the count carries through zero. Both variants read back their presets, and the narrow variant shows whether the seven-bit reduction and the period field are placed correctly.

// File: rtl/systime_pkg.sv
package systime_pkg;

  localparam logic [1:0] ADR_INC = 2'd0;
  localparam logic [1:0] ADR_TLO = 2'd1;
  localparam logic [1:0] ADR_THI = 2'd2;

  typedef enum logic [1:0] {
    SPD_10G    = 2'd0,
    SPD_1G     = 2'd1,
    SPD_100M   = 2'd2,
    SPD_NOLINK = 2'd3
  } link_spd_e;

  localparam int unsigned NARROW_DROP = 7;

  function automatic logic [31:0] base_inc(input link_spd_e spd);
    case (spd)
      SPD_1G:   return 32'h4000_0000;
      SPD_100M: return 32'h5000_0000;
      default:  return 32'h6666_6666;
    endcase
  endfunction

  function automatic logic [5:0] base_shift(input link_spd_e spd);
    case (spd)
      SPD_1G:   return 6'd24;
      SPD_100M: return 6'd21;
      default:  return 6'd28;
    endcase
  endfunction

endpackage

// File: rtl/systime_inc_sel.sv
module systime_inc_sel
  import systime_pkg::*;
#(
  parameter bit          NARROW = 1'b0,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned INC_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [1:0]        speed,
  input  logic              wr_inc,
  input  logic [WORD_W-1:0] wdata,
  output logic [INC_W-1:0]  inc,
  output logic [WORD_W-1:0] inc_rd,
  output logic [5:0]        shift
);

  localparam int unsigned DROP  = NARROW ? NARROW_DROP : 0;
  localparam int unsigned PER_W = WORD_W - INC_W;

  logic [INC_W-1:0] inc_q, inc_d;
  logic [5:0]       shf_q, shf_d;
  logic             inc_en;
  logic [WORD_W-1:0] preset_full;

  assign preset_full = WORD_W'(base_inc(link_spd_e'(speed)) >> DROP);
  assign inc_en      = apply | wr_inc;

  always_comb begin
    inc_d = inc_q;
    shf_d = shf_q;
    if (apply) begin
      inc_d = preset_full[INC_W-1:0];
      shf_d = base_shift(link_spd_e'(speed)) - 6'(DROP);
    end else if (wr_inc) begin
      inc_d = wdata[INC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= INC_W'(32'h6666_6666 >> DROP);
      shf_q <= 6'd28 - 6'(DROP);
    end else if (inc_en) begin
      inc_q <= inc_d;
      shf_q <= shf_d;
    end
  end

  assign inc   = inc_q;
  assign shift = shf_q;

  generate
    if (NARROW) begin : g_narrow
      logic [PER_W-1:0] per_q, per_d;
      always_comb begin
        per_d = per_q;
        if (apply)       per_d = PER_W'(1);
        else if (wr_inc) per_d = wdata[WORD_W-1:INC_W];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      per_q <= PER_W'(1);
        else if (inc_en) per_q <= per_d;
      end
      assign inc_rd = {per_q, inc_q};
    end else begin : g_wide
      logic unused_hi;
      assign unused_hi = ^wdata[WORD_W-1:INC_W];
      assign inc_rd = {{PER_W{1'b0}}, inc_q};
    end
  endgenerate

  // R3: increment only moves on a write or preset
  p_inc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply && !wr_inc) |=> $stable(inc_q));
  // R9: preset wins over a same-cycle write
  p_apply_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && wr_inc && speed == 2'd1) |=> shf_q == 6'd24 - 6'(DROP));

endmodule

// File: rtl/systime_counter.sv
module systime_counter #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned INC_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  input  logic [INC_W-1:0]  inc,
  output logic [TIME_W-1:0] count
);

  logic [TIME_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = tick | load;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (tick) cnt_d = cnt_q + TIME_W'(inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R1: a tick adds the increment in force during that cycle
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> cnt_q == $past(cnt_q) + TIME_W'($past(inc)));
  // R1: no tick, no load, no change
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  // R5: a load lands exactly, whatever the tick does
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));

endmodule

// File: rtl/systime_regif.sv
module systime_regif
  import systime_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [TIME_W-1:0] time_val,
  input  logic [WORD_W-1:0] inc_rd,
  output logic              wr_inc,
  output logic              load,
  output logic [TIME_W-1:0] load_val,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);

  logic [WORD_W-1:0] lo_q, shadow_q, rdata_q, rdata_d;
  logic              rvalid_q;
  logic              lo_en, shadow_en;

  assign wr_inc    = wr_en && (addr == ADR_INC);
  assign load      = wr_en && (addr == ADR_THI);
  assign lo_en     = wr_en && (addr == ADR_TLO);
  assign shadow_en = rd_en && (addr == ADR_TLO);
  assign load_val  = {wdata, lo_q};

  always_comb begin
    case (addr)
      ADR_INC: rdata_d = inc_rd;
      ADR_TLO: rdata_d = time_val[WORD_W-1:0];
      ADR_THI: rdata_d = shadow_q;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (shadow_en) shadow_q <= time_val[TIME_W-1:WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rd_en;
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // R6: a low read freezes the high half seen at that edge
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_en |=> shadow_q == $past(time_val[TIME_W-1:WORD_W]));
  // R6: read data appears one cycle after the strobe
  p_rvalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid_q);
  // R4: staging the low half does not touch the high capture
  p_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_en) |=> $stable(shadow_q));

endmodule

// File: rtl/systime_accum.sv
module systime_accum #(
  parameter bit          NARROW = 1'b0,
  parameter int unsigned WORD_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_tick,
  input  logic [1:0]    link_speed,
  input  logic          speed_apply,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_rvalid,
  output logic [63:0]   time_now,
  output logic [5:0]    frac_shift
);

  localparam int unsigned TIME_W = 2 * WORD_W;
  localparam int unsigned INC_W  = NARROW ? 24 : 31;

  logic [INC_W-1:0]  inc;
  logic [WORD_W-1:0] inc_rd;
  logic              wr_inc, load;
  logic [TIME_W-1:0] load_val, count;

  systime_inc_sel #(.NARROW(NARROW), .WORD_W(WORD_W), .INC_W(INC_W)) u_inc (
    .clk(clk), .rst_n(rst_n), .apply(speed_apply), .speed(link_speed),
    .wr_inc(wr_inc), .wdata(reg_wdata), .inc(inc), .inc_rd(inc_rd),
    .shift(frac_shift)
  );

  systime_counter #(.TIME_W(TIME_W), .INC_W(INC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .load(load),
    .load_val(load_val), .inc(inc), .count(count)
  );

  systime_regif #(.WORD_W(WORD_W), .TIME_W(TIME_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .time_val(count), .inc_rd(inc_rd),
    .wr_inc(wr_inc), .load(load), .load_val(load_val),
    .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  assign time_now = count;

  // R7: carry out of the top bit wraps to the low end
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && !load && count == '1 && inc == INC_W'(1)) |=> count == '0);

endmodule

// File: tb/systime_accum_bench.sv
`timescale 1ns/1ps
module systime_accum_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        osc_tick, speed_apply, reg_wr, reg_rd;
  logic [1:0]  link_speed, reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_rvalid;
  logic [63:0] time_now;
  logic [5:0]  frac_shift;

  logic        n_tick, n_apply, n_rd;
  logic [31:0] n_rdata;
  logic        n_rvalid;
  logic [63:0] n_time;
  logic [5:0]  n_shift;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  logic [63:0] m_time;
  logic [63:0] m_inc;

  always #2.5 clk = ~clk;

  systime_accum u_systime_accum (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .link_speed(link_speed),
    .speed_apply(speed_apply), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .time_now(time_now), .frac_shift(frac_shift)
  );

  systime_accum #(.NARROW(1'b1)) u_narrow (
    .clk(clk), .rst_n(rst_n), .osc_tick(n_tick), .link_speed(link_speed),
    .speed_apply(n_apply), .reg_wr(1'b0), .reg_rd(n_rd),
    .reg_addr(reg_addr), .reg_wdata(32'h0), .reg_rdata(n_rdata),
    .reg_rvalid(n_rvalid), .time_now(n_time), .frac_shift(n_shift)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (sb_q.size() == 0) check("R6 unexpected read", 64'(reg_rdata), 64'hx);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, 64'(reg_rdata), 64'(e.val));
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    sb_q.push_back('{val: exp, tag: tag});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit with_tick);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; osc_tick = with_tick;
    @(negedge clk);
    reg_wr = 1'b0; osc_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    osc_tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m_time = m_time + m_inc;
    end
    osc_tick = 1'b0;
  endtask

  task automatic preset(input logic [1:0] spd);
    @(negedge clk);
    link_speed = spd; speed_apply = 1'b1;
    @(negedge clk);
    speed_apply = 1'b0;
  endtask

  task automatic n_read_inc(input logic [31:0] exp, input string tag);
    @(negedge clk);
    n_rd = 1'b1; reg_addr = 2'd0;
    @(negedge clk);
    n_rd = 1'b0;
    check(tag, 64'(n_rdata), 64'(exp));
  endtask

  task automatic drain;
    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", 64'(sb_q.size()), 64'd0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; osc_tick = 0; speed_apply = 0; reg_wr = 0; reg_rd = 0;
    link_speed = 2'd0; reg_addr = 2'd0; reg_wdata = '0;
    n_tick = 0; n_apply = 0; n_rd = 0;
    m_time = 0; m_inc = 64'h6666_6666;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2 reset time", time_now, 64'd0);
    check("R2 reset shift", 64'(frac_shift), 64'd28);
    rd(2'd0, 32'h6666_6666, "R2 reset increment");
    rd(2'd3, 32'h0, "R6 unused address");

    // R1 stepping and holding
    ticks(5);
    check("R1 five ticks", time_now, m_time);
    repeat (3) @(negedge clk);
    check("R1 hold without tick", time_now, m_time);

    // R2 presets per rate
    preset(2'd1);
    check("R2 1G shift", 64'(frac_shift), 64'd24);
    rd(2'd0, 32'h4000_0000, "R2 1G increment");
    preset(2'd2);
    check("R2 100M shift", 64'(frac_shift), 64'd21);
    rd(2'd0, 32'h5000_0000, "R2 100M increment");
    preset(2'd3);
    check("R2 no-link shift", 64'(frac_shift), 64'd28);
    rd(2'd0, 32'h6666_6666, "R2 no-link increment");
    check("R2 preset leaves time", time_now, m_time);

    // R9 preset beats a same-cycle increment write
    @(negedge clk);
    link_speed = 2'd1; speed_apply = 1'b1;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_1234;
    @(negedge clk);
    speed_apply = 1'b0; reg_wr = 1'b0;
    m_inc = 64'h4000_0000;
    rd(2'd0, 32'h4000_0000, "R9 preset wins");

    // R3 trim: same-cycle tick uses the old increment
    wr(2'd0, 32'h0001_2345, 1'b1);
    m_time = m_time + m_inc;
    m_inc  = 64'h1_2345;
    check("R3 tick during write uses old", time_now, m_time);
    ticks(1);
    check("R3 next tick uses new", time_now, m_time);
    wr(2'd0, 32'hFFFF_FFFF, 1'b0);
    rd(2'd0, 32'h7FFF_FFFF, "R3 bit 31 dropped");
    check("R3 write leaves time", time_now, m_time);
    wr(2'd0, 32'h0001_2345, 1'b0);

    // R4 staging the low half
    wr(2'd1, 32'hAAAA_5555, 1'b0);
    check("R4 low write no effect", time_now, m_time);

    // R5 high write loads, tick in same cycle ignored
    wr(2'd2, 32'h0000_0005, 1'b1);
    m_time = 64'h5_AAAA_5555;
    check("R5 load over tick", time_now, m_time);

    // R6 coherent read across a carry
    wr(2'd0, 32'h0000_0020, 1'b0);
    m_inc = 64'h20;
    wr(2'd1, 32'hFFFF_FFF0, 1'b0);
    wr(2'd2, 32'h0, 1'b0);
    m_time = 64'hFFFF_FFF0;
    rd(2'd1, 32'hFFFF_FFF0, "R6 low before carry");
    ticks(1);
    check("R6 carry reached", time_now, 64'h1_0000_0010);
    rd(2'd2, 32'h0, "R6 high is captured");
    rd(2'd1, 32'h0000_0010, "R6 low after carry");
    rd(2'd2, 32'h1, "R6 high recaptured");

    // R7 wrap
    wr(2'd0, 32'h2, 1'b0);
    m_inc = 64'h2;
    wr(2'd1, 32'hFFFF_FFFF, 1'b0);
    wr(2'd2, 32'hFFFF_FFFF, 1'b0);
    m_time = 64'hFFFF_FFFF_FFFF_FFFF;
    ticks(1);
    check("R7 wrap through zero", time_now, 64'h1);
    drain();

    // R8 narrow variant
    n_read_inc(32'h01CC_CCCC, "R8 narrow reset increment");
    check("R8 narrow reset shift", 64'(n_shift), 64'd21);
    @(negedge clk); n_tick = 1'b1;
    @(negedge clk); @(negedge clk); n_tick = 1'b0;
    check("R8 narrow two ticks", n_time, 64'h0199_9998);
    link_speed = 2'd1;
    @(negedge clk); n_apply = 1'b1;
    @(negedge clk); n_apply = 1'b0;
    n_read_inc(32'h0180_0000, "R8 narrow 1G increment");
    check("R8 narrow 1G shift", 64'(n_shift), 64'd17);
    link_speed = 2'd2;
    @(negedge clk); n_apply = 1'b1;
    @(negedge clk); n_apply = 1'b0;
    n_read_inc(32'h01A0_0000, "R8 narrow 100M increment");
    check("R8 narrow 100M shift", 64'(n_shift), 64'd14);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule